// File: doc/BRIEF.md
# Peripheral Event Level Controller

This block collects a vector of peripheral interrupt lines and steers each one onto one of the general-purpose event levels of a sixteen-level event space. Every level has a pending bit and an enable bit. A pending bit is set by a rising edge on the combined sources of its level. The block presents the most urgent level that is both pending and enabled to the core as a request, made of a valid flag and a level number.

Software reaches the block through a word-addressed register port. The port has a supervisor qualifier that gates every write. Each source has a programmable 4-bit routing field, with eight fields packed into each 32-bit routing register. Reset gives the fields fixed defaults that group the sources by type. When the core takes a request it pulses an accept input, and the pending bit of the granted level clears.

Top module: `evc_top`

## Requirements
- R1: After reset the pending register and the enable register read 0 and `req_valid` is 0.
- R2: After reset the routing fields hold fixed defaults. Sources 0–10 and 60–63 go to level 7. Sources 11–22 and 53–54 go to level 8. Sources 23–34 and 55–56 go to level 9. Sources 35–46 go to level 10. Sources 47–52 go to level 11. Sources 57–58 go to level 12. Source 59 goes to level 13.
- R3: Source j has a 4-bit field in bits [4*(j%8)+3 : 4*(j%8)] of routing register j/8. A field value v from 0 to 8 routes the source to level 7+v. A value from 9 to 15 connects the source to no level.
- R4: A pending bit is set one clock edge after the OR of all sources routed to its level goes from 0 to 1. A source that stays high does not set the bit again after it has been cleared.
- R5: A pending bit whose enable bit is 0 takes no part in the request but stays pending. Enable bit value 1 means enabled.
- R6: `req_valid` is 1 exactly when some level is both pending and enabled. `req_level` then gives the lowest-numbered such level.
- R7: When `core_ack` is 1, the pending bit of the requested level clears at the next edge. If a new rising edge for that level arrives in the same cycle, the bit stays set.
- R8: A write to the pending register clears each bit written as 1, but only when `reg_sup` is 1 and that level's enable bit is 0. All other bits are unchanged.
- R9: Writes to the enable register and to the routing registers take effect only when `reg_sup` is 1. Otherwise they are ignored.
- R10: Reads work in any mode through a combinational `reg_rdata`. Word address 0 is the pending register in bits 15:0. Address 1 is the enable register. Addresses 2 to 9 are routing registers 0 to 7. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_sup | input | 1 | Supervisor qualifier for writes |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_src | input | 64 | Peripheral interrupt lines |
| core_ack | input | 1 | Core accepts the current request |
| req_valid | output | 1 | A pending, enabled level exists |
| req_level | output | 4 | Level number of the request |

## Verification
The bench builds the block with its defaults: 64 sources and therefore eight routing registers. With these values every reset-default field group can be read back, including the last register, which mixes four different default levels. Seven levels can be made pending at once, so a table of enable patterns can test the priority order and the masking of pending levels against one fixed pending set. Level 15 and a disconnecting field value are reached by reprogramming a single field.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int LVL_N      = 16;
  localparam int LVL_W      = 4;
  localparam int FIELD_W    = 4;
  localparam int GP_BASE    = 7;
  localparam int GP_SPAN    = 9;
  localparam int FLD_PER_RG = 8;
  localparam int RG_W       = 32;

  // reset routing offset for a source index
  function automatic logic [FIELD_W-1:0] dflt_offset(input int s);
    if (s <= 10)      return 4'd0;
    else if (s <= 22) return 4'd1;
    else if (s <= 34) return 4'd2;
    else if (s <= 46) return 4'd3;
    else if (s <= 52) return 4'd4;
    else if (s <= 54) return 4'd1;
    else if (s <= 56) return 4'd2;
    else if (s <= 58) return 4'd5;
    else if (s == 59) return 4'd6;
    else              return 4'd0;
  endfunction

  // bit 4 = routed, bits 3:0 = level
  function automatic logic [LVL_W:0] field_to_level(input logic [FIELD_W-1:0] f);
    if (int'(f) < GP_SPAN) return {1'b1, LVL_W'(int'(f) + GP_BASE)};
    else                   return '0;
  endfunction

  function automatic logic [LVL_W-1:0] lowest_set(input logic [LVL_N-1:0] v);
    for (int i = 0; i < LVL_N; i++)
      if (v[i]) return LVL_W'(i);
    return '0;
  endfunction
endpackage

// File: rtl/evc_route.sv
module evc_route
  import evc_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC*FIELD_W-1:0] fields,
  input  logic [NUM_SRC-1:0]         src,
  output logic [LVL_N-1:0]           lvl_or
);
  always_comb begin
    lvl_or = '0;
    for (int j = 0; j < NUM_SRC; j++) begin
      logic [LVL_W:0] dec;
      dec = field_to_level(fields[FIELD_W*j +: FIELD_W]);
      if (dec[LVL_W] && src[j]) lvl_or[dec[LVL_W-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/evc_pending.sv
module evc_pending
  import evc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_N-1:0] lvl_or,
  input  logic [LVL_N-1:0] sw_clr,
  input  logic [LVL_N-1:0] ack_clr,
  output logic [LVL_N-1:0] lat,
  output logic [LVL_N-1:0] rise
);
  logic [LVL_N-1:0] prev_q;

  assign rise = lvl_or & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat    <= '0;
    end else begin
      prev_q <= lvl_or;
      lat    <= (lat & ~sw_clr & ~ack_clr) | rise;
    end
  end

  for (genvar i = 0; i < LVL_N; i++) begin : g_chk
    // R4
    rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise[i] |=> lat[i]);
    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_clr[i] && !rise[i]) |=> !lat[i]);
  end
endmodule

// File: rtl/evc_prio.sv
module evc_prio
  import evc_pkg::*;
(
  input  logic [LVL_N-1:0] pend,
  output logic             valid,
  output logic [LVL_W-1:0] level,
  output logic [LVL_N-1:0] grant
);
  always_comb begin
    valid = |pend;
    level = valid ? lowest_set(pend) : '0;
    grant = valid ? (LVL_N'(1) << level) : '0;
  end

  always_comb begin
    // R6
    grant_onehot_chk: assert ($onehot0(grant));
  end
endmodule

// File: rtl/evc_top.sv
module evc_top
  import evc_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [RG_W-1:0]    reg_wdata,
  input  logic               reg_sup,
  output logic [RG_W-1:0]    reg_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               core_ack,
  output logic               req_valid,
  output logic [LVL_W-1:0]   req_level
);
  localparam int NUM_RG   = (NUM_SRC + FLD_PER_RG - 1) / FLD_PER_RG;
  localparam int A_PEND   = 0;
  localparam int A_ENABLE = 1;
  localparam int A_ROUTE  = 2;

  logic [LVL_N-1:0] mask_q, lat, rise, lvl_or, sw_clr, ack_clr, grant;
  logic [RG_W-1:0]  rte_q [NUM_RG];
  logic [NUM_SRC*FIELD_W-1:0] fields;
  logic wr_sup, wr_pend;

  assign wr_sup  = reg_wr && reg_sup;
  assign wr_pend = wr_sup && (reg_addr == ADDR_W'(A_PEND));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      for (int k = 0; k < NUM_RG; k++) rte_q[k] <= '0;
      for (int j = 0; j < NUM_SRC; j++)
        rte_q[j/FLD_PER_RG][FIELD_W*(j%FLD_PER_RG) +: FIELD_W] <= dflt_offset(j);
    end else if (wr_sup) begin
      if (reg_addr == ADDR_W'(A_ENABLE)) mask_q <= reg_wdata[LVL_N-1:0];
      for (int k = 0; k < NUM_RG; k++)
        if (reg_addr == ADDR_W'(A_ROUTE + k)) rte_q[k] <= reg_wdata;
    end
  end

  always_comb begin
    for (int j = 0; j < NUM_SRC; j++)
      fields[FIELD_W*j +: FIELD_W] = rte_q[j/FLD_PER_RG][FIELD_W*(j%FLD_PER_RG) +: FIELD_W];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_PEND))   reg_rdata = {{(RG_W-LVL_N){1'b0}}, lat};
    if (reg_addr == ADDR_W'(A_ENABLE)) reg_rdata = {{(RG_W-LVL_N){1'b0}}, mask_q};
    for (int k = 0; k < NUM_RG; k++)
      if (reg_addr == ADDR_W'(A_ROUTE + k)) reg_rdata = rte_q[k];
  end

  assign sw_clr  = wr_pend ? (reg_wdata[LVL_N-1:0] & ~mask_q) : '0;
  assign ack_clr = core_ack ? grant : '0;

  evc_route #(.NUM_SRC(NUM_SRC)) u_route (
    .fields (fields),
    .src    (irq_src),
    .lvl_or (lvl_or)
  );

  evc_pending u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_or  (lvl_or),
    .sw_clr  (sw_clr),
    .ack_clr (ack_clr),
    .lat     (lat),
    .rise    (rise)
  );

  evc_prio u_prio (
    .pend  (lat & mask_q),
    .valid (req_valid),
    .level (req_level),
    .grant (grant)
  );

  // R9
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sup) |=> $stable(mask_q));
  // R5
  req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (lat[req_level] && mask_q[req_level]));

  for (genvar i = 0; i < LVL_N; i++) begin : g_cancel
    // R8
    enabled_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(A_PEND) && mask_q[i] && lat[i] && !ack_clr[i]) |=> lat[i]);
  end
endmodule

// File: tb/sim_evc_top.sv
module sim_evc_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  reg_addr = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic        reg_sup = 0;
  logic [31:0] reg_rdata;
  logic [63:0] irq_src = 0;
  logic        core_ack = 0;
  logic        req_valid;
  logic [3:0]  req_level;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  evc_top u0 (.clk, .rst_n, .reg_addr, .reg_wr, .reg_wdata, .reg_sup, .reg_rdata,
              .irq_src, .core_ack, .req_valid, .req_level);

  // {enable pattern, expected valid, expected level}
  localparam logic [20:0] VEC [8] = '{
    {16'h0000, 1'b0, 4'd0},
    {16'hFFFF, 1'b1, 4'd7},
    {16'h0100, 1'b1, 4'd8},
    {16'h3000, 1'b1, 4'd12},
    {16'h2400, 1'b1, 4'd10},
    {16'h0040, 1'b0, 4'd0},
    {16'hC000, 1'b0, 4'd0},
    {16'h2000, 1'b1, 4'd13}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic sup);
    reg_addr = a; reg_wdata = d; reg_sup = sup; reg_wr = 1;
    tick();
    reg_wr = 0; reg_sup = 0;
  endtask

  // reads are done with reg_sup low (R10)
  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic pulse(input int s);
    irq_src[s] = 1; tick(); irq_src[s] = 0; tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    rd("R1 pend", 4'd0, 32'h0);
    rd("R1 enable", 4'd1, 32'h0);
    check("R1 valid", {31'b0, req_valid}, 32'h0);
    // R2 default routing
    rd("R2 rte0", 4'd2, 32'h00000000);
    rd("R2 rte1", 4'd3, 32'h11111000);
    rd("R2 rte2", 4'd4, 32'h21111111);
    rd("R2 rte3", 4'd5, 32'h22222222);
    rd("R2 rte7", 4'd9, 32'h00006552);
    rd("R10 unmapped", 4'd15, 32'h0);
    // R4 edges latch levels 7..13 via default routing
    irq_src[0] = 1; irq_src[11] = 1; irq_src[23] = 1; irq_src[35] = 1;
    irq_src[47] = 1; irq_src[57] = 1; irq_src[59] = 1;
    tick();
    irq_src = '0;
    tick();
    rd("R4 pend set", 4'd0, 32'h00003F80);
    // R5/R6 table walk
    for (int v = 0; v < 8; v++) begin
      wr(4'd1, {16'h0, VEC[v][20:5]}, 1'b1);
      rd("R9 enable write", 4'd1, {16'h0, VEC[v][20:5]});
      check("R5 valid", {31'b0, req_valid}, {31'b0, VEC[v][4]});
      if (VEC[v][4]) check("R6 level", {28'b0, req_level}, {28'b0, VEC[v][3:0]});
    end
    rd("R5 still pending", 4'd0, 32'h00003F80);
    // R8 cancel gating (enable = 0x2000)
    wr(4'd0, 32'hFFFF, 1'b0);
    rd("R8 user cancel", 4'd0, 32'h00003F80);
    wr(4'd0, 32'hFFFF, 1'b1);
    rd("R8 sup cancel", 4'd0, 32'h00002000);
    // R7 accept
    wr(4'd1, 32'hFFFF, 1'b1);
    check("R7 level", {28'b0, req_level}, 32'd13);
    core_ack = 1; tick(); core_ack = 0;
    rd("R7 ack clr", 4'd0, 32'h0);
    check("R7 valid", {31'b0, req_valid}, 32'h0);
    pulse(0);
    rd("R4 lvl7", 4'd0, 32'h00000080);
    irq_src[1] = 1; core_ack = 1; tick(); core_ack = 0;
    rd("R7 same-cycle reset", 4'd0, 32'h00000080);
    core_ack = 1; tick(); core_ack = 0;
    rd("R4 steady no reset", 4'd0, 32'h0);
    irq_src[1] = 0; tick();
    // R9 user writes ignored
    wr(4'd1, 32'h0, 1'b0);
    rd("R9 enable kept", 4'd1, 32'h0000FFFF);
    wr(4'd2, 32'h00000800, 1'b0);
    rd("R9 route kept", 4'd2, 32'h0);
    // R3 field encoding
    wr(4'd2, 32'h00000800, 1'b1);
    rd("R3 route write", 4'd2, 32'h00000800);
    pulse(2);
    rd("R3 level15", 4'd0, 32'h00008000);
    check("R6 lvl15", {27'b0, req_valid, req_level}, {27'b0, 1'b1, 4'd15});
    wr(4'd1, 32'h0, 1'b1);
    wr(4'd0, 32'h8000, 1'b1);
    rd("R8 cleared", 4'd0, 32'h0);
    wr(4'd2, 32'h00000900, 1'b1);
    pulse(2);
    rd("R3 disconnected", 4'd0, 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule